// File: doc/BRIEF.md
# Configurable UART Serial Frame Engine

This block is the bit-level core of an asynchronous serial port. A 21-bit divisor sets the bit rate. The divisor is split into a 16-bit low word and a 5-bit high word, and a tick generator derives sixteen sample ticks per bit from it. A 6-bit line-control word selects the data length (5 to 8 bits), the parity (none, even or odd) and the stop length (one or two bits). The transmitter takes a byte from a transmit FIFO through a valid/ready handshake and shifts it out LSB first.

The receiver synchronises its input line and confirms each start bit at mid-bit. It then samples every following bit at its centre. Each delivered character carries a status byte that flags break, overrun, framing and parity errors. A loopback control connects the transmitter output internally to the receiver input. The register bus, the interrupt logic and the FIFO storage sit outside this block.

Top module: `uart_frame_core`

## Requirements
- R1: The bit period is 16 × P clock cycles, where P = {div_hi, div_lo} >> 4. A value of P equal to 0 is treated as 1. Both divisor words take part in the division.
- R2: lcr[3:2] sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Received data is right-aligned, and the unused upper bits read 0.
- R3: lcr[1] = 1 adds a parity bit after the data. lcr[0] = 1 selects odd parity and lcr[0] = 0 selects even parity. The parity bit makes the count of ones across data and parity odd or even, as selected.
- R4: lcr[5] = 1 gives two stop bits, and lcr[5] = 0 gives one stop bit (line-control value 01 or 11 in lcr[5:4]).
- R5: The transmit frame has these parts, in this order: a low start bit, the data LSB first, the optional parity bit, and high stop bits. The line rests high between frames. Every transmitted bit, including the start bit, lasts exactly one bit period.
- R6: tx_ready and tx_done are high after reset. Both go low from the cycle after a byte is accepted (tx_valid && tx_ready at a clock edge) until the last stop bit has finished.
- R7: A received character is signalled by a one-cycle rx_valid pulse, together with rx_data and rx_status.
- R8: rx_status bit 3 (framing) is set when any stop bit is sampled low.
- R9: rx_status bit 2 (parity) is set when parity is enabled and the received parity bit does not match the data.
- R10: A frame whose data, parity and stop positions are all sampled low sets rx_status bit 7 (break) and delivers data 0. In that case bits 3 and 2 are cleared. The receiver does not look for a new start bit until the line has returned high.
- R11: A character that completes while rx_full is high is dropped, with no rx_valid. The next delivered character has rx_status bit 4 (overrun) set, and the character after that has bit 4 clear.
- R12: With loop_en high, the transmitter output drives the receiver, rxd is ignored, and the txd pin stays high.
- R13: A low pulse on the receive line that is shorter than half a bit is rejected as a false start, and no character is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_lo | input | 16 | Divisor bits [15:0] |
| div_hi | input | 5 | Divisor bits [20:16] |
| lcr | input | 6 | Line control: [5:4] stop, [3:2] length, [1] parity enable, [0] odd |
| loop_en | input | 1 | Internal loopback enable |
| tx_data | input | 8 | Byte from the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_ready | output | 1 | Byte accepted this cycle when tx_valid is also high |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Transmitter has finished all frames |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_full | input | 1 | Receive FIFO is full |
| rx_valid | output | 1 | Push strobe to the receive FIFO |
| rx_data | output | 8 | Received character |
| rx_status | output | 8 | Per-character errors: [7] break, [4] overrun, [3] framing, [2] parity |

## Verification
The hardest condition to reach from the ports is overrun. It needs a character to finish while the receive FIFO is reported full, and the error must then appear on a later, different character. The bench drives rx_full high for the whole of one frame, confirms that no push occurs, and then checks bit 4 on the next two frames. Break is reached by holding rxd low past a full frame, which also shows that the receiver waits for a high line before it looks for the next start bit. A quarter-bit glitch exercises start-bit rejection. Loopback sweeps over every length, parity and stop setting.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int DIV_W   = 21;
  localparam int OSR_LOG = 4;
  localparam int FRAME_W = 12;          // start + 8 data + parity + 2 stop
  localparam int RBITS_W = FRAME_W - 1; // everything after the start bit

  typedef enum logic [1:0] {RX_HUNT, RX_IDLE, RX_START, RX_BITS} rx_state_t;

  function automatic logic [3:0] data_len(input logic [5:0] lcr);
    return 4'd5 + {2'b00, lcr[3:2]};
  endfunction

  function automatic logic [7:0] len_mask(input logic [3:0] len);
    return 8'hFF >> (4'd8 - len);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [5:0] lcr);
    return (^(d & len_mask(data_len(lcr)))) ^ lcr[0];
  endfunction

  function automatic logic [3:0] frame_bits(input logic [5:0] lcr);
    return 4'd1 + data_len(lcr) + {3'b000, lcr[1]} + (lcr[5] ? 4'd2 : 4'd1);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
                                                     input logic [5:0] lcr);
    logic [FRAME_W-1:0] v;
    logic [3:0] len;
    len  = data_len(lcr);
    v    = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < len) v[1+i] = d[i];
    if (lcr[1]) v[4'd1 + len] = par_bit(d, lcr);
    return v;
  endfunction
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W   = 21,
  parameter int OSR_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int PW = DIV_W - OSR_LOG;
  logic [PW-1:0] pre, cnt;

  assign pre = (divisor[DIV_W-1:OSR_LOG] == '0) ? PW'(1) : divisor[DIV_W-1:OSR_LOG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= pre - PW'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + PW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [5:0] lcr,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line,
  output logic       done
);
  logic               pending, busy;
  logic [7:0]         hold;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         left, phase;

  assign ready = !busy && !pending;
  assign done  = !busy && !pending;
  assign line  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      hold    <= '0;
      sh      <= '1;
      left    <= '0;
      phase   <= '0;
    end else begin
      if (valid && ready) begin
        pending <= 1'b1;
        hold    <= data;
      end
      if (tick) begin
        if (busy) begin
          phase <= phase + 4'd1;
          if (phase == 4'd15) begin
            if (left == 4'd1) busy <= 1'b0;
            else begin
              sh   <= {1'b1, sh[FRAME_W-1:1]};
              left <= left - 4'd1;
            end
          end
        end else if (pending) begin
          busy    <= 1'b1;
          pending <= 1'b0;
          sh      <= build_frame(hold, lcr);
          left    <= frame_bits(lcr);
          phase   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_serial.sv
module uart_rx_serial
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [5:0] lcr,
  input  logic       line,
  input  logic       fifo_full,
  output logic       push,
  output logic [7:0] data,
  output logic [7:0] status,
  output logic       frame_end
);
  rx_state_t          st;
  logic [3:0]         cnt, idx, total, len, sidx;
  logic [RBITS_W-1:0] rbits, nbits, tmask;
  logic [7:0]         dval;
  logic               ovr_pend, brk, fe, pe;

  assign total = frame_bits(lcr) - 4'd1;
  assign len   = data_len(lcr);
  assign sidx  = len + {3'b000, lcr[1]};
  assign nbits = rbits | (RBITS_W'(line) << idx);
  assign tmask = ~(RBITS_W'('1) << total);
  assign dval  = nbits[7:0] & len_mask(len);
  assign brk   = (nbits & tmask) == '0;
  assign fe    = !brk && (!nbits[sidx] || (lcr[5] && !nbits[sidx + 4'd1]));
  assign pe    = !brk && lcr[1] && (nbits[len] != par_bit(dval, lcr));
  assign frame_end = tick && (st == RX_BITS) && (cnt == 4'd15) && (idx == total - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_HUNT;
      cnt      <= '0;
      idx      <= '0;
      rbits    <= '0;
      ovr_pend <= 1'b0;
      push     <= 1'b0;
      data     <= '0;
      status   <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_HUNT: if (line) st <= RX_IDLE;
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              st    <= line ? RX_IDLE : RX_BITS;
              cnt   <= '0;
              idx   <= '0;
              rbits <= '0;
            end
          end
          RX_BITS: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              rbits <= nbits;
              idx   <= idx + 4'd1;
              if (frame_end) begin
                st <= line ? RX_IDLE : RX_HUNT;
                if (fifo_full) ovr_pend <= 1'b1;
                else begin
                  push     <= 1'b1;
                  data     <= dval;
                  status   <= {brk, 2'b00, ovr_pend, fe, pe, 2'b00};
                  ovr_pend <= 1'b0;
                end
              end
            end
          end
          default: st <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core
  import uart_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] div_lo,
  input  logic [4:0]  div_hi,
  input  logic [5:0]  lcr,
  input  logic        loop_en,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        txd,
  output logic        tx_done,
  input  logic        rxd,
  input  logic        rx_full,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic [7:0]  rx_status
);
  logic       bit_tick, tx_line, rx_src, frame_end;
  logic [1:0] rx_sync;

  uart_baud_tick #(.DIV_W(DIV_W), .OSR_LOG(OSR_LOG)) tick_i (
    .clk(clk), .rst_n(rst_n), .divisor({div_hi, div_lo}), .tick(bit_tick));

  uart_tx_serial tx_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .lcr(lcr), .data(tx_data),
    .valid(tx_valid), .ready(tx_ready), .line(tx_line), .done(tx_done));

  assign rx_src = loop_en ? tx_line : rxd;
  assign txd    = loop_en ? 1'b1 : tx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx_src};
  end

  uart_rx_serial rx_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .lcr(lcr), .line(rx_sync[1]),
    .fifo_full(rx_full), .push(rx_valid), .data(rx_data), .status(rx_status),
    .frame_end(frame_end));
endmodule

// File: rtl/uart_frame_core_chk.sv
module uart_frame_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        frame_end,
  input logic [15:0] div_lo,
  input logic [4:0]  div_hi,
  input logic        loop_en,
  input logic        txd,
  input logic        tx_done,
  input logic        rx_full,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic [7:0]  rx_status
);
  logic [16:0] pre;
  assign pre = {div_hi, div_lo[15:4]};

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre > 17'd1) |=> !tick);
  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !loop_en) |-> txd);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && !loop_en) |-> !tx_done);
  assert_push_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(frame_end));
  assert_single_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_break_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_status[7]) |-> (rx_status[3:2] == 2'b00 && rx_data == 8'h00));
  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(rx_full));
  assert_loop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> txd);
endmodule

bind uart_frame_core uart_frame_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .frame_end(frame_end),
  .div_lo(div_lo), .div_hi(div_hi), .loop_en(loop_en), .txd(txd),
  .tx_done(tx_done), .rx_full(rx_full), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_status(rx_status));

// File: tb/uart_frame_core_tb_top.sv
module uart_frame_core_tb_top;
  localparam int BITC = 32; // divisor 32 -> 2 clocks per tick
  logic clk = 0, rst_n = 0;
  logic [15:0] div_lo = 16'd32;
  logic [4:0]  div_hi = 5'd0;
  logic [5:0]  lcr = 6'b011100;
  logic loop_en = 0, tx_valid = 0, rxd = 1, rx_full = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, txd, tx_done, rx_valid;
  logic [7:0] rx_data, rx_status;
  int checks = 0, fails = 0, rx_cnt = 0;
  logic [7:0] last_d, last_s;

  always #10 clk = ~clk;

  uart_frame_core dut_i (.*);

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++; last_d = rx_data; last_s = rx_status;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mk_lcr(int lc, int pm, int two);
    return {two ? 2'b11 : 2'b01, 2'(lc), pm == 0 ? 2'b00 : (pm == 1 ? 2'b10 : 2'b11)};
  endfunction

  // expected frame built from the requirement text: returns bit count
  function automatic int exp_frame(logic [7:0] b, logic [5:0] l, output logic [11:0] f);
    int n = 5 + l[3:2];
    int ones = 0;
    int p = 0;
    f = '1;
    f[p++] = 1'b0;
    for (int i = 0; i < n; i++) begin f[p++] = b[i]; ones += b[i]; end
    if (l[1]) f[p++] = l[0] ? ~ones[0] : ones[0];
    p += l[5] ? 2 : 1;
    return p;
  endfunction

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1;
    forever begin
      if (tx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    tx_valid = 0;
  endtask

  task automatic wait_rx(input int old, input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      if (rx_cnt != old) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic drive_bits(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic start_len(output int n);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin n++; @(negedge clk); end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] f, got_f;
    int n, old, m;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(tx_ready && tx_done, "R6 reset idle", {tx_ready, tx_done}, 3);
    check(txd == 1 && rx_valid == 0, "R5 reset line", txd, 1);

    // R2 R3 R4 R12: loopback sweep of every configuration
    loop_en = 1;
    rxd = 0; // R12: external rxd must be ignored
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int two = 0; two < 2; two++)
          foreach (f[k]) if (k < 2) begin
            logic [7:0] b;
            b = (k == 0) ? 8'hA5 : 8'(8'h3C + lc * 7 + pm * 3 + two);
            lcr = mk_lcr(lc, pm, two);
            old = rx_cnt;
            push_tx(b);
            if (lc == 0 && pm == 0 && two == 0 && k == 0)
              check(!tx_done && !tx_ready, "R6 busy after accept", tx_done, 0);
            wait_rx(old, 20 * BITC, got);
            check(got, "R12 loopback char", got, 1);
            check(last_d == (b & (8'hFF >> (3 - lc))), "R2 R3 R4 loop data",
                  last_d, b & (8'hFF >> (3 - lc)));
            check(last_s == 0, "R7 loop status", last_s, 0);
            while (!tx_done) @(negedge clk);
          end
    rxd = 1;
    loop_en = 0;
    repeat (2 * BITC) @(negedge clk);

    // R5: decode external txd against expected frames
    foreach (f[k]) if (k < 3) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h96 : (k == 1 ? 8'h4B : 8'h71);
      lcr = (k == 0) ? mk_lcr(3, 2, 1) : (k == 1 ? mk_lcr(2, 1, 0) : mk_lcr(0, 0, 0));
      n = exp_frame(b, lcr, f);
      push_tx(b);
      while (txd) @(negedge clk);
      repeat (BITC / 2) @(negedge clk);
      got_f = '1;
      for (int i = 0; i < n; i++) begin
        got_f[i] = txd;
        repeat (BITC) @(negedge clk);
      end
      check(got_f == f, "R5 R3 tx frame", got_f, f);
      while (!tx_done) @(negedge clk);
      check(tx_done && tx_ready, "R6 done after stop", tx_done, 1);
    end

    // receive error cases: 8 data, even parity, two stops
    lcr = mk_lcr(3, 1, 1);
    n = exp_frame(8'h5A, lcr, f);
    f[9] = ~f[9];
    old = rx_cnt; drive_bits(f, n); wait_rx(old, 2, got);
    check(got && last_s == 8'h04 && last_d == 8'h5A, "R9 parity error", last_s, 8'h04);

    n = exp_frame(8'hC3, lcr, f);
    f[11] = 1'b0;
    old = rx_cnt; drive_bits(f, n); wait_rx(old, 2, got);
    check(got && last_s == 8'h08, "R8 framing on second stop", last_s, 8'h08);

    old = rx_cnt; drive_bits(12'h000, 12 + 3); wait_rx(old, 2, got);
    check(got && last_s == 8'h80 && last_d == 0, "R10 break flags", last_s, 8'h80);
    check(rx_cnt == old + 1, "R10 one char per break", rx_cnt - old, 1);
    n = exp_frame(8'h81, lcr, f);
    old = rx_cnt; drive_bits(f, n); wait_rx(old, 2, got);
    check(got && last_s == 0 && last_d == 8'h81, "R10 resume after break", last_d, 8'h81);

    old = rx_cnt;
    rxd = 0; repeat (BITC / 4) @(negedge clk); rxd = 1;
    repeat (3 * BITC) @(negedge clk);
    check(rx_cnt == old, "R13 glitch rejected", rx_cnt - old, 0);

    rx_full = 1;
    n = exp_frame(8'h11, lcr, f);
    old = rx_cnt; drive_bits(f, n);
    check(rx_cnt == old, "R11 dropped when full", rx_cnt - old, 0);
    rx_full = 0;
    n = exp_frame(8'h22, lcr, f);
    drive_bits(f, n); wait_rx(old, 2, got);
    check(got && last_s == 8'h10 && last_d == 8'h22, "R11 overrun flagged", last_s, 8'h10);
    n = exp_frame(8'h33, lcr, f);
    old = rx_cnt; drive_bits(f, n); wait_rx(old, 2, got);
    check(got && last_s == 8'h00, "R11 overrun cleared", last_s, 0);

    // R1: divisor sweep, start bit width
    lcr = mk_lcr(3, 0, 0);
    div_lo = 16'd64;
    push_tx(8'h01); start_len(m);
    check(m == 64, "R1 divisor 64", m, 64);
    while (!tx_done) @(negedge clk);
    div_lo = 16'd5;
    push_tx(8'h01); start_len(m);
    check(m == 16, "R1 divisor below 16", m, 16);
    while (!tx_done) @(negedge clk);
    div_lo = 16'd0; div_hi = 5'd1;
    push_tx(8'h01); start_len(m);
    check(m == 65536, "R1 high divisor word", m, 65536);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(tx_done && txd, "R6 idle after reset", tx_done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule